// File: doc/BRIEF.md
# Mark-Space Pulse Width Modulation Channel

This block produces one pulse width modulated output from two programmed values. A period value sets how many PWM ticks make one cycle. A high-count value sets how many of those ticks, at the start of each cycle, the output stays high. A separate clock block supplies the PWM tick as a one-cycle enable on the system clock. This block holds the period counter, the compare, and a small word-addressed register file that software uses to program the channel.

Software first turns the channel off. It then writes the period and the high count, and turns the channel on again. Values written while the channel runs are not lost: they are loaded at the next period boundary, so the output never shows a period made of two settings. Four sticky event flags report period boundaries, writes made while the channel runs, and degenerate settings. Software clears each flag by writing a one to its bit.

Top module: `pwm_ms_chan`

## Requirements
- R1: After reset the control, status, period and high-count registers read zero and `pwm_out` is low.
- R2: Register word offsets are: control at 0, status at 1, period at 4, high count at 5. Control reads back only bit 0 (enable) and bit 7 (mode), with all other bits zero. Period and high count read back their low CNT_W bits. Any other offset reads zero, and a write to it changes no register.
- R3: While the channel is enabled, the counter steps through 0 to period-1, advancing once per tick. After k ticks from enable, `pwm_out` is high exactly when (k mod period) < high count. A period of 0 acts as a period of 1.
- R4: When the high count is equal to or above the period, the output stays high. A high count of 0 keeps the output low.
- R5: With period 2 and high count 1, the output changes level on every tick.
- R6: A period or high-count write made while the channel runs takes effect only at the next wrap of the counter. The period in progress finishes with the old values.
- R7: While enable is 0, `pwm_out` is low and the counter is held at zero. After the channel is enabled again, it starts at count 0 using the register values current at that moment.
- R8: In a cycle with no tick, the counter and the output keep their values.
- R9: Status bit 0 sets at every counter wrap. Bit 1 sets when the period or high count is written while enabled. Bit 2 sets at a wrap that loads a period of 0. Bit 3 sets at a wrap that loads a nonzero period together with a high count at or above it.
- R10: Writing to status clears each flag whose bit in the written value is 1. Flags whose written bit is 0 keep their value.
- R11: Control bit 7 has no effect on the output waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | PWM tick enable, one clock wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word offset |
| wdata | input | DATA_W | Register write data |
| rdata | output | DATA_W | Register read data, combinational, zero when rd_en is low |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest case to reach is a write that lands in the middle of a running period. The bench has to show that the old high count still governs the rest of that period and the new one only starts after the wrap. To do this, the bench holds the tick high continuously and issues the data write on the exact cycle after the first tick. It then checks every following tick against a schedule worked out by hand. The main waveform check is a sweep over every period from 1 to 6 and every high count from 0 to 7. Over two full periods per setting, each sample is compared against the modulo rule.

// File: rtl/pwm_ms_pkg.sv
package pwm_ms_pkg;
   localparam int OFF_CTRL = 0;
   localparam int OFF_STAT = 1;
   localparam int OFF_PER  = 4;
   localparam int OFF_HIGH = 5;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_MODE_BIT = 7;

   localparam int NUM_FLAGS = 4;
   localparam int FLG_WRAP  = 0;
   localparam int FLG_LIVE  = 1;
   localparam int FLG_ZPER  = 2;
   localparam int FLG_SAT   = 3;

   typedef struct packed {
      logic mode;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/pwm_ms_regs.sv
module pwm_ms_regs
   import pwm_ms_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_FLAGS-1:0] core_evt,
   output logic [DATA_W-1:0]    rdata,
   output ctrl_t                ctrl,
   output logic [CNT_W-1:0]     per_q,
   output logic [CNT_W-1:0]     high_q
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(OFF_PER);
   localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(OFF_HIGH);

   logic hit_ctrl, hit_stat, hit_per, hit_high;
   logic [NUM_FLAGS-1:0] stat_q;
   logic [NUM_FLAGS-1:0] flag_set;
   logic                 live_write;

   assign hit_ctrl = (addr == A_CTRL);
   assign hit_stat = (addr == A_STAT);
   assign hit_per  = (addr == A_PER);
   assign hit_high = (addr == A_HIGH);

   assign live_write = wr_en && ctrl.en && (hit_per || hit_high);

   always_comb begin
      flag_set           = core_evt;
      flag_set[FLG_LIVE] = core_evt[FLG_LIVE] | live_write;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl   <= '0;
         per_q  <= '0;
         high_q <= '0;
      end else if (wr_en) begin
         if (hit_ctrl) begin
            ctrl.en   <= wdata[CTRL_EN_BIT];
            ctrl.mode <= wdata[CTRL_MODE_BIT];
         end
         if (hit_per)  per_q  <= wdata[CNT_W-1:0];
         if (hit_high) high_q <= wdata[CNT_W-1:0];
      end
   end

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n)                           q <= 1'b0;
         else if (flag_set[i])                 q <= 1'b1;
         else if (wr_en && hit_stat && wdata[i]) q <= 1'b0;
      end
      assign stat_q[i] = q;
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (hit_ctrl) begin
            rdata[CTRL_EN_BIT]   = ctrl.en;
            rdata[CTRL_MODE_BIT] = ctrl.mode;
         end
         if (hit_stat) rdata[NUM_FLAGS-1:0] = stat_q;
         if (hit_per)  rdata = DATA_W'(per_q);
         if (hit_high) rdata = DATA_W'(high_q);
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;
endmodule

// File: rtl/pwm_ms_core.sv
module pwm_ms_core
   import pwm_ms_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 en,
   input  logic [CNT_W-1:0]     per_cfg,
   input  logic [CNT_W-1:0]     high_cfg,
   output logic [CNT_W-1:0]     cnt_o,
   output logic [CNT_W-1:0]     act_per_o,
   output logic                 raw_out,
   output logic [NUM_FLAGS-1:0] evt
);
   logic [CNT_W-1:0] cnt_q, act_per_q, act_high_q;
   logic [CNT_W-1:0] last_val;
   logic             at_last, wrap;

   assign last_val = (act_per_q == '0) ? '0 : act_per_q - CNT_W'(1);
   assign at_last  = (cnt_q >= last_val);
   assign wrap     = en && tick && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         act_per_q  <= '0;
         act_high_q <= '0;
      end else if (!en) begin
         cnt_q      <= '0;
         act_per_q  <= per_cfg;
         act_high_q <= high_cfg;
      end else if (tick) begin
         if (at_last) begin
            cnt_q      <= '0;
            act_per_q  <= per_cfg;
            act_high_q <= high_cfg;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   always_comb begin
      evt           = '0;
      evt[FLG_WRAP] = wrap;
      evt[FLG_ZPER] = wrap && (per_cfg == '0);
      evt[FLG_SAT]  = wrap && (per_cfg != '0) && (high_cfg >= per_cfg);
   end

   assign raw_out   = en && (cnt_q < act_high_q);
   assign cnt_o     = cnt_q;
   assign act_per_o = act_per_q;
endmodule

// File: rtl/pwm_ms_outstage.sv
module pwm_ms_outstage #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (REG_OUT) begin : g_flop
      logic q_r;
      always_ff @(posedge clk) begin
         if (!rst_n) q_r <= 1'b0;
         else        q_r <= d;
      end
      assign q = q_r;
   end else begin : g_wire
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q = d;
   end
endmodule

// File: rtl/pwm_ms_chan.sv
module pwm_ms_chan
   import pwm_ms_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              pwm_out
);
   if (ADDR_W < 3) begin : g_bad_addr
      $error("pwm_ms_chan: ADDR_W must be at least 3");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("pwm_ms_chan: CNT_W must not exceed DATA_W");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("pwm_ms_chan: DATA_W must be at least 8");
   end

   ctrl_t                ctrl;
   logic                 ctrl_en;
   logic [CNT_W-1:0]     per_q, high_q;
   logic [CNT_W-1:0]     cnt_q, act_per_q;
   logic                 raw_out;
   logic [NUM_FLAGS-1:0] core_evt;

   assign ctrl_en = ctrl.en;

   pwm_ms_regs #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .CNT_W (CNT_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .wdata   (wdata),
      .core_evt(core_evt),
      .rdata   (rdata),
      .ctrl    (ctrl),
      .per_q   (per_q),
      .high_q  (high_q)
   );

   pwm_ms_core #(
      .CNT_W(CNT_W)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .en       (ctrl_en),
      .per_cfg  (per_q),
      .high_cfg (high_q),
      .cnt_o    (cnt_q),
      .act_per_o(act_per_q),
      .raw_out  (raw_out),
      .evt      (core_evt)
   );

   pwm_ms_outstage #(
      .REG_OUT(REG_OUT)
   ) u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_out),
      .q    (pwm_out)
   );

   logic unused_mode;
   assign unused_mode = ctrl.mode;
endmodule

// File: rtl/pwm_ms_chk.sv
module pwm_ms_chk #(
   parameter int CNT_W   = 16,
   parameter bit REG_OUT = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             ctrl_en,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] act_per_q,
   input logic             pwm_out
);
   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) || (cnt_q < act_per_q));

   assert_held_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |=> (cnt_q == '0));

   if (REG_OUT) begin : g_off_reg
      assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_en |=> !pwm_out);
   end else begin : g_off_comb
      assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_en |-> !pwm_out);
   end

   assert_no_tick_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && !tick) |=> $stable(cnt_q));

   assert_shadow_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_en && $past(ctrl_en) && cnt_q != '0) |-> $stable(act_per_q));
endmodule

bind pwm_ms_chan pwm_ms_chk #(
   .CNT_W  (CNT_W),
   .REG_OUT(REG_OUT)
) u_pwm_ms_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .ctrl_en  (ctrl_en),
   .cnt_q    (cnt_q),
   .act_per_q(act_per_q),
   .pwm_out  (pwm_out)
);

// File: tb/pwm_ms_chan_bench.sv
module pwm_ms_chan_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        pwm_out;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pwm_ms_chan u_pwm_ms_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic bus_wr(input int a, input logic [31:0] v);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'(a); wdata = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input int a, output logic [31:0] v);
      rd_en = 1'b1; addr = 3'(a);
      #1 v = rdata;
      rd_en = 1'b0;
   endtask

   task automatic check_reg(input int a, input logic [31:0] exp, input string req);
      logic [31:0] v;
      bus_rd(a, v);
      chk(v === exp, req, v, exp);
   endtask

   task automatic setup(input int per, input int high, input logic [31:0] ctl);
      tick = 1'b0;
      bus_wr(0, 0);
      bus_wr(4, per);
      bus_wr(5, high);
      bus_wr(0, ctl);
   endtask

   task automatic chk_out(input bit exp, input string req);
      chk(pwm_out === exp, req, {31'd0, pwm_out}, {31'd0, exp});
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_reg(0, 0, "R1 ctrl");
      check_reg(1, 0, "R1 status");
      check_reg(4, 0, "R1 period");
      check_reg(5, 0, "R1 high");
      chk_out(1'b0, "R1 out");

      // R2 map and readback
      bus_wr(0, 32'hFFFF_FFFF);
      check_reg(0, 32'h81, "R2 ctrl readback");
      bus_wr(0, 0);
      bus_wr(4, 32'h0001_2345);
      check_reg(4, 32'h2345, "R2 period width");
      bus_wr(3, 32'hFFFF);
      bus_wr(2, 32'hFFFF);
      check_reg(4, 32'h2345, "R2 unmapped write");
      check_reg(5, 0, "R2 unmapped write high");
      check_reg(3, 0, "R2 unmapped read 3");
      check_reg(2, 0, "R2 unmapped read 2");
      check_reg(6, 0, "R2 unmapped read 6");
      check_reg(7, 0, "R2 unmapped read 7");

      // R3 R4 R5 R11 sweep
      for (int per = 1; per <= 6; per++) begin
         for (int high = 0; high <= 7; high++) begin
            string req;
            if (high == 0 || high >= per) req = "R4";
            else if (per == 2 && high == 1) req = "R5";
            else if (per % 2 == 1) req = "R11";
            else req = "R3";
            setup(per, high, (per % 2 == 1) ? 32'h81 : 32'h01);
            tick = 1'b1;
            for (int k = 0; k < 2 * per; k++) begin
               chk_out((k % per) < high, req);
               @(negedge clk);
            end
            tick = 1'b0;
         end
      end

      // R10 clear all
      bus_wr(0, 0);
      bus_wr(1, 32'hF);
      check_reg(1, 0, "R10 clear all");

      // R9 wrap and saturation flags
      setup(2, 3, 32'h1);
      tick = 1'b1;
      @(negedge clk); @(negedge clk);
      tick = 1'b0;
      bus_wr(0, 0);
      check_reg(1, 32'h9, "R9 wrap+sat");
      bus_wr(1, 32'h1);
      check_reg(1, 32'h8, "R10 partial clear");
      bus_wr(1, 32'h8);
      check_reg(1, 32'h0, "R10 clear bit3");

      // R3 period zero, R9 zero flag
      setup(0, 1, 32'h1);
      tick = 1'b1;
      for (int k = 0; k < 3; k++) begin
         chk_out(1'b1, "R3 period0");
         @(negedge clk);
      end
      tick = 1'b0;
      bus_wr(0, 0);
      check_reg(1, 32'h5, "R9 zero period");
      bus_wr(1, 32'hF);

      // R6 live write deferred to wrap
      setup(4, 1, 32'h1);
      tick = 1'b1;
      chk_out(1'b1, "R6 k0");
      @(negedge clk);
      chk_out(1'b0, "R6 k1");
      wr_en = 1'b1; addr = 3'd5; wdata = 32'd3;
      @(negedge clk);
      wr_en = 1'b0;
      chk_out(1'b0, "R6 k2 old value");
      @(negedge clk); chk_out(1'b0, "R6 k3");
      @(negedge clk); chk_out(1'b1, "R6 k4 new value");
      @(negedge clk); chk_out(1'b1, "R6 k5");
      @(negedge clk); chk_out(1'b1, "R6 k6");
      @(negedge clk); chk_out(1'b0, "R6 k7");
      tick = 1'b0;
      bus_wr(0, 0);
      check_reg(1, 32'h3, "R9 live write flag");
      bus_wr(1, 32'hF);

      // R7 disable and restart
      setup(4, 9, 32'h1);
      tick = 1'b1;
      chk_out(1'b1, "R7 running");
      @(negedge clk); @(negedge clk);
      chk_out(1'b1, "R7 running sat");
      bus_wr(0, 0);
      for (int k = 0; k < 3; k++) begin
         chk_out(1'b0, "R7 disabled low");
         @(negedge clk);
      end
      bus_wr(5, 1);
      bus_wr(0, 1);
      chk_out(1'b1, "R7 restart count0");
      @(negedge clk);
      chk_out(1'b0, "R7 restart count1");
      tick = 1'b0;

      // R8 tick hold
      setup(4, 2, 32'h1);
      tick = 1'b1;
      chk_out(1'b1, "R8 k0");
      @(negedge clk);
      chk_out(1'b1, "R8 k1");
      tick = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk_out(1'b1, "R8 hold");
      end
      tick = 1'b1;
      @(negedge clk);
      chk_out(1'b0, "R8 resume k2");
      tick = 1'b0;
      bus_wr(0, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule